// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host writes control words and count bytes and reads count and status bytes through a 2-bit address, an 8-bit write bus, an 8-bit read bus, and read and write strobes. Addresses 0 to 2 reach the data port of channels 0 to 2. Address 3 takes control words.

A control word can do one of three things. It can program a channel's access type, mode and BCD flag. It can freeze a channel's live count. It can issue a read-back command that freezes count, status or both on any subset of the channels. Count bytes are assembled into 16-bit values and handed to the selected channel as a one-cycle load pulse.

On reads the block returns, in order of precedence, a frozen status byte, a frozen count, or the live count the channel presents. The counting logic lives in separate channel blocks. They receive the count, load, mode and BCD signals and return a live count, an output level and a transfer acknowledge.

Top module: `timer_regif`

## Requirements
- R1: After reset every channel has access type low-then-high (code 11), mode 0 and BCD 0; chLoad and chCount are zero; no latch is pending; the null-count flag is clear.
- R2: A write to address 3 with bits 7:6 = c (0..2) and bits 5:4 ≠ 00 sets channel c's access type to bits 5:4, its BCD flag to bit 0 and its mode to bits 3:1, where modes 6 and 7 become 2 and 3. Other channels keep their settings, and no other write alters chMode or chBcd.
- R3: With access type 01, a data write of byte d loads {8'h00, d}. With access type 10, it loads {d, 8'h00}. The load appears as a one-cycle chLoad pulse on that channel only, in the cycle after the write, with chCount holding the value.
- R4: With access type 11, the first data write produces no load. The second write loads {second, first}.
- R5: Without a pending latch, a read returns the live count's low byte for access 01 and its high byte for access 10. For access 11 it alternates, starting with the low byte.
- R6: A control word that programs a channel returns both its read and write byte order to the low byte.
- R7: A control word with bits 5:4 = 00 freezes the selected channel's live count at that write. Reads then return the frozen value whatever the live count does.
- R8: A frozen count is read once and released under access 01 or 10. Under access 11 it is read as the low byte, then the high byte, and released after the high byte. Later reads return the live count.
- R9: A count-freeze or status-freeze request for a channel is ignored while an earlier freeze of the same kind is unread.
- R10: A write to address 3 with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 = 0 freezes the count and bit 4 = 0 freezes the status. Unselected channels are untouched.
- R11: The status byte is {output level, null count, access[1:0], mode[2:0], BCD}, bit 7 first. A pending status is returned before a pending count and is released after that single read.
- R12: The null-count flag (status bit 6) is set by a programming control word or by a completed count load. It is cleared by a chLoaded pulse on that channel. When both happen in one cycle, it stays set.
- R13: A read of address 3 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0..2 channel data, 3 control |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe; read state advances at the clock edge |
| rdData | output | 8 | Read byte, valid while rdEn and addr are held |
| chCount | output | 48 | Loaded 16-bit count per channel, channel 0 in the low bits |
| chLoad | output | 3 | One-cycle load pulse per channel |
| chMode | output | 9 | 3-bit mode per channel |
| chBcd | output | 3 | BCD flag per channel |
| chLive | input | 48 | Live 16-bit count from each channel |
| chOut | input | 3 | Output level from each channel |
| chLoaded | input | 3 | Pulse from a channel when a written count has been transferred |

## Verification
A single read-back write can freeze both the count and the status of a channel in the same cycle. The bench issues a combined read-back on channels 0 and 2 and then reads each of them. The first byte must be the status, followed by the frozen count bytes and then the live count, while the unselected channel keeps returning live data. The transfer acknowledge can also coincide with a programming control word. The bench holds chLoaded high across that write and then requires status bit 6 to remain set.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;
  localparam int BW  = 8;
  localparam int CW  = 2 * BW;
  localparam int AW  = 2;
  localparam int NCH = (1 << AW) - 1;
  localparam int MW  = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic ctrlWr;
    logic cntLatch;
    logic stsLatch;
    logic dataWr;
    logic dataRd;
  } chStrb_t;
endpackage

// File: rtl/timer_regif_ctrl.sv
module timer_regif_ctrl
  import timer_regif_pkg::*;
(
  input  logic [AW-1:0]          addr,
  input  logic                   wrEn,
  input  logic [BW-1:1]          cmd,
  input  logic                   rdEn,
  output chStrb_t [NCH-1:0]      strb
);
  logic ctrlSel;
  logic isReadBack;

  assign ctrlSel    = wrEn && (addr == AW'(NCH));
  assign isReadBack = ctrlSel && (cmd[7:6] == 2'b11);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic hit;
      logic rbSel;
      hit   = ctrlSel && (cmd[7:6] == 2'(c));
      rbSel = isReadBack && cmd[c+1];
      strb[c].ctrlWr   = hit && (cmd[5:4] != ACC_LATCH);
      strb[c].cntLatch = (hit && (cmd[5:4] == ACC_LATCH)) || (rbSel && !cmd[5]);
      strb[c].stsLatch = rbSel && !cmd[4];
      strb[c].dataWr   = wrEn && (addr == AW'(c));
      strb[c].dataRd   = rdEn && (addr == AW'(c));
    end
  end
endmodule

// File: rtl/timer_regif_data.sv
module timer_regif_data
  import timer_regif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  chStrb_t [NCH-1:0]    strb,
  input  logic [BW-1:0]        wrData,
  input  logic [AW-1:0]        addr,
  input  logic [NCH*CW-1:0]    chLive,
  input  logic [NCH-1:0]       chOut,
  input  logic [NCH-1:0]       chLoaded,
  output logic [NCH*CW-1:0]    chCount,
  output logic [NCH-1:0]       chLoad,
  output logic [NCH*MW-1:0]    chMode,
  output logic [NCH-1:0]       chBcd,
  output logic [BW-1:0]        rdData
);
  logic [BW-1:0] rdByte [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chStrb_t        s;
    acc_e           acc;
    logic [MW-1:0]  mode;
    logic           bcd;
    logic           wrHi;
    logic           rdHi;
    logic [BW-1:0]  wrHold;
    logic           cntLat;
    acc_e           latAcc;
    logic           latHi;
    logic [CW-1:0]  latVal;
    logic           stsLat;
    logic [BW-1:0]  stsVal;
    logic           nullCnt;
    logic [CW-1:0]  cntReg;
    logic           loadReg;
    logic [CW-1:0]  live;
    logic           loadNow;
    logic [CW-1:0]  loadVal;
    logic [MW-1:0]  newMode;
    logic           liveRead;

    assign s    = strb[c];
    assign live = chLive[c*CW +: CW];

    // Mode codes 6 and 7 alias onto 2 and 3.
    assign newMode = (wrData[3] && wrData[2]) ? {1'b0, wrData[2:1]} : wrData[3:1];
    assign liveRead = s.dataRd && !stsLat && !cntLat;

    always_comb begin
      loadNow = 1'b0;
      loadVal = '0;
      if (s.dataWr) begin
        case (acc)
          ACC_LO: begin
            loadNow = 1'b1;
            loadVal = {{BW{1'b0}}, wrData};
          end
          ACC_HI: begin
            loadNow = 1'b1;
            loadVal = {wrData, {BW{1'b0}}};
          end
          ACC_LOHI: begin
            loadNow = wrHi;
            loadVal = {wrData, wrHold};
          end
          default: ;
        endcase
      end
    end

    always_comb begin
      if (stsLat) begin
        rdByte[c] = stsVal;
      end else if (cntLat) begin
        case (latAcc)
          ACC_LO:  rdByte[c] = latVal[BW-1:0];
          ACC_HI:  rdByte[c] = latVal[CW-1:BW];
          default: rdByte[c] = latHi ? latVal[CW-1:BW] : latVal[BW-1:0];
        endcase
      end else begin
        case (acc)
          ACC_LO:  rdByte[c] = live[BW-1:0];
          ACC_HI:  rdByte[c] = live[CW-1:BW];
          default: rdByte[c] = rdHi ? live[CW-1:BW] : live[BW-1:0];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc     <= ACC_LOHI;
        mode    <= '0;
        bcd     <= 1'b0;
        wrHi    <= 1'b0;
        rdHi    <= 1'b0;
        wrHold  <= '0;
        cntLat  <= 1'b0;
        latAcc  <= ACC_LOHI;
        latHi   <= 1'b0;
        latVal  <= '0;
        stsLat  <= 1'b0;
        stsVal  <= '0;
        nullCnt <= 1'b0;
        cntReg  <= '0;
        loadReg <= 1'b0;
      end else begin
        loadReg <= loadNow;
        if (loadNow) cntReg <= loadVal;

        if (s.ctrlWr) begin
          acc  <= acc_e'(wrData[5:4]);
          mode <= newMode;
          bcd  <= wrData[0];
          wrHi <= 1'b0;
          rdHi <= 1'b0;
        end else begin
          if (s.dataWr && acc == ACC_LOHI) begin
            wrHi <= !wrHi;
            if (!wrHi) wrHold <= wrData;
          end
          if (liveRead && acc == ACC_LOHI) rdHi <= !rdHi;
        end

        // Setting takes precedence over the transfer acknowledge.
        if (s.ctrlWr || loadNow) nullCnt <= 1'b1;
        else if (chLoaded[c])    nullCnt <= 1'b0;

        if (s.cntLatch && !cntLat) begin
          cntLat <= 1'b1;
          latVal <= live;
          latAcc <= acc;
          latHi  <= 1'b0;
        end else if (s.dataRd && !stsLat && cntLat) begin
          if (latAcc == ACC_LOHI && !latHi) latHi  <= 1'b1;
          else                              cntLat <= 1'b0;
        end

        if (s.stsLatch && !stsLat) begin
          stsLat <= 1'b1;
          stsVal <= {chOut[c], nullCnt, acc, mode, bcd};
        end else if (s.dataRd && stsLat) begin
          stsLat <= 1'b0;
        end
      end
    end

    assign chCount[c*CW +: CW] = cntReg;
    assign chLoad[c]           = loadReg;
    assign chMode[c*MW +: MW]  = mode;
    assign chBcd[c]            = bcd;
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(c)) rdData = rdByte[c];
    end
  end
endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import timer_regif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AW-1:0]        addr,
  input  logic                 wrEn,
  input  logic [BW-1:0]        wrData,
  input  logic                 rdEn,
  output logic [BW-1:0]        rdData,
  output logic [NCH*CW-1:0]    chCount,
  output logic [NCH-1:0]       chLoad,
  output logic [NCH*MW-1:0]    chMode,
  output logic [NCH-1:0]       chBcd,
  input  logic [NCH*CW-1:0]    chLive,
  input  logic [NCH-1:0]       chOut,
  input  logic [NCH-1:0]       chLoaded
);
  chStrb_t [NCH-1:0] strb;

  timer_regif_ctrl u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .cmd    (wrData[BW-1:1]),
    .rdEn   (rdEn),
    .strb   (strb)
  );

  timer_regif_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .addr     (addr),
    .chLive   (chLive),
    .chOut    (chOut),
    .chLoaded (chLoaded),
    .chCount  (chCount),
    .chLoad   (chLoad),
    .chMode   (chMode),
    .chBcd    (chBcd),
    .rdData   (rdData)
  );
endmodule

// File: rtl/timer_regif_chk.sv
module timer_regif_chk
  import timer_regif_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [AW-1:0]       addr,
  input logic                wrEn,
  input logic [BW-1:0]       wrData,
  input logic                rdEn,
  input logic [BW-1:0]       rdData,
  input logic [NCH-1:0]      chLoad,
  input logic [NCH*MW-1:0]   chMode,
  input logic [NCH-1:0]      chBcd
);
  function automatic logic [MW-1:0] expMode(input logic [MW-1:0] m);
    return (m > 3'd5) ? m - 3'd4 : m;
  endfunction

  p_single_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chLoad));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == AW'(NCH)) |=> ($stable(chMode) && $stable(chBcd)));

  p_ctl_read_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == AW'(NCH)) |-> (rdData == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_load_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
      chLoad[c] |-> $past(wrEn && addr == AW'(c)));

    p_mode_program_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == AW'(NCH) && wrData[7:6] == 2'(c) && wrData[5:4] != 2'b00)
      |=> (chMode[c*MW +: MW] == expMode($past(wrData[3:1])) && chBcd[c] == $past(wrData[0])));
  end
endmodule

bind timer_regif timer_regif_chk u_chk (.*);

// File: tb/timer_regif_bench.sv
module timer_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] chCount;
  logic [2:0]  chLoad;
  logic [8:0]  chMode;
  logic [2:0]  chBcd;
  logic [47:0] chLive = '0;
  logic [2:0]  chOut = '0;
  logic [2:0]  chLoaded = '0;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  logic [2:0] expM [3];
  logic       expB [3];

  timer_regif u_timer_regif (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .chCount(chCount), .chLoad(chLoad),
    .chMode(chMode), .chBcd(chBcd), .chLive(chLive), .chOut(chOut),
    .chLoaded(chLoaded)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 2'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = 2'(a); rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setLive(input int ch, input logic [15:0] v);
    chLive[ch*16 +: 16] = v;
  endtask

  function automatic logic [7:0] ctl(input int ch, input logic [1:0] acc, input logic [2:0] m, input logic b);
    return {2'(ch), acc, m, b};
  endfunction

  // Read-back, status only, for one channel: bits 7:6=11, bit5=1, bit4=0.
  task automatic readStatus(input int ch, output logic [7:0] v);
    wr(3, {4'b1110, 3'(1 << ch), 1'b0});
    rd(ch, v);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 chLoad", 32'(chLoad), 0);
    chk("R1 chCount", 32'(chCount[31:0]), 0);
    chk("R1 chMode", 32'(chMode), 0);
    chk("R1 chBcd", 32'(chBcd), 0);
    for (int ch = 0; ch < 3; ch++) begin
      chOut[ch] = ch[0];
      readStatus(ch, v);
      chk("R1 status", 32'(v), 32'({ch[0], 1'b0, 2'b11, 3'b000, 1'b0}));
      expM[ch] = 3'd0; expB[ch] = 1'b0;
    end

    // R2 sweep of channel, mode and BCD
    for (int ch = 0; ch < 3; ch++)
      for (int m = 0; m < 8; m++)
        for (int b = 0; b < 2; b++) begin
          wr(3, ctl(ch, 2'b01, 3'(m), b[0]));
          expM[ch] = (m > 5) ? 3'(m - 4) : 3'(m);
          expB[ch] = b[0];
          for (int k = 0; k < 3; k++) begin
            chk("R2 mode", 32'(chMode[k*3 +: 3]), 32'(expM[k]));
            chk("R2 bcd", 32'(chBcd[k]), 32'(expB[k]));
          end
        end

    // R3 single-byte loads
    for (int ch = 0; ch < 3; ch++)
      for (int hi = 0; hi < 2; hi++) begin
        wr(3, ctl(ch, hi ? 2'b10 : 2'b01, 3'd2, 1'b0));
        for (int d = 0; d < 256; d += 37) begin
          wr(ch, 8'(d));
          chk("R3 load pulse", 32'(chLoad), 32'(1 << ch));
          chk("R3 load value", 32'(chCount[ch*16 +: 16]), hi ? 32'(d << 8) : 32'(d));
        end
        @(negedge clk);
        chk("R3 pulse ends", 32'(chLoad), 0);
      end

    // R4 low-then-high loads
    for (int ch = 0; ch < 3; ch++) begin
      wr(3, ctl(ch, 2'b11, 3'd0, 1'b0));
      for (int d = 0; d < 256; d += 51) begin
        wr(ch, 8'(d));
        chk("R4 no load on first byte", 32'(chLoad), 0);
        wr(ch, 8'(255 - d));
        chk("R4 load pulse", 32'(chLoad), 32'(1 << ch));
        chk("R4 load value", 32'(chCount[ch*16 +: 16]), 32'(((255 - d) << 8) | d));
      end
    end

    // R5 live reads per access type
    for (int ch = 0; ch < 3; ch++) begin
      setLive(ch, 16'hA100 + 16'(ch * 16'h0111));
      wr(3, ctl(ch, 2'b01, 3'd0, 1'b0));
      rd(ch, v); chk("R5 lo only", 32'(v), 32'(chLive[ch*16 +: 8]));
      rd(ch, v); chk("R5 lo only again", 32'(v), 32'(chLive[ch*16 +: 8]));
      wr(3, ctl(ch, 2'b10, 3'd0, 1'b0));
      rd(ch, v); chk("R5 hi only", 32'(v), 32'(chLive[ch*16+8 +: 8]));
      wr(3, ctl(ch, 2'b11, 3'd0, 1'b0));
      rd(ch, v); chk("R5 lohi first", 32'(v), 32'(chLive[ch*16 +: 8]));
      rd(ch, v); chk("R5 lohi second", 32'(v), 32'(chLive[ch*16+8 +: 8]));
      rd(ch, v); chk("R5 lohi third", 32'(v), 32'(chLive[ch*16 +: 8]));
      // R6 reprogramming resets the read order
      wr(3, ctl(ch, 2'b11, 3'd0, 1'b0));
      rd(ch, v); chk("R6 read order reset", 32'(v), 32'(chLive[ch*16 +: 8]));
      // R6 reprogramming resets the write order
      wr(ch, 8'h11);
      wr(3, ctl(ch, 2'b11, 3'd0, 1'b0));
      wr(ch, 8'h22);
      chk("R6 write order reset, no load", 32'(chLoad), 0);
      wr(ch, 8'h33);
      chk("R6 write order reset value", 32'(chCount[ch*16 +: 16]), 32'h3322);
    end

    // R7, R8 count latch in lo-hi access
    setLive(1, 16'h1234);
    wr(3, ctl(1, 2'b11, 3'd0, 1'b0));
    wr(3, ctl(1, 2'b00, 3'd0, 1'b0));
    setLive(1, 16'hBEEF);
    rd(1, v); chk("R7 frozen low", 32'(v), 32'h34);
    rd(1, v); chk("R8 frozen high", 32'(v), 32'h12);
    rd(1, v); chk("R8 released to live", 32'(v), 32'hEF);
    rd(1, v); chk("R8 live high", 32'(v), 32'hBE);

    // R8 single-byte latch released after one read
    wr(3, ctl(2, 2'b01, 3'd0, 1'b0));
    setLive(2, 16'h5566);
    wr(3, ctl(2, 2'b00, 3'd0, 1'b0));
    setLive(2, 16'h7788);
    rd(2, v); chk("R8 single frozen", 32'(v), 32'h66);
    rd(2, v); chk("R8 single released", 32'(v), 32'h88);

    // R9 second latch ignored while unread
    setLive(1, 16'hAAAA);
    wr(3, ctl(1, 2'b00, 3'd0, 1'b0));
    setLive(1, 16'hCCDD);
    wr(3, ctl(1, 2'b00, 3'd0, 1'b0));
    rd(1, v); chk("R9 first latch kept low", 32'(v), 32'hAA);
    rd(1, v); chk("R9 first latch kept high", 32'(v), 32'hAA);
    wr(3, ctl(1, 2'b00, 3'd0, 1'b0));
    setLive(1, 16'h0F0F);
    rd(1, v); chk("R9 new latch after release", 32'(v), 32'hDD);
    rd(1, v); chk("R9 new latch high", 32'(v), 32'hCC);

    // R10, R11 combined read-back on channels 0 and 2
    wr(3, ctl(0, 2'b11, 3'd3, 1'b1));
    wr(3, ctl(1, 2'b11, 3'd1, 1'b0));
    wr(3, ctl(2, 2'b11, 3'd5, 1'b0));
    setLive(0, 16'h0102); setLive(1, 16'h0304); setLive(2, 16'h0506);
    chOut = 3'b101;
    wr(3, 8'b1100_1010);
    setLive(0, 16'hF0E0); setLive(1, 16'hD0C0); setLive(2, 16'hB0A0);
    chOut = 3'b000;
    rd(0, v); chk("R11 status first ch0", 32'(v), 32'({1'b1, 1'b1, 2'b11, 3'd3, 1'b1}));
    rd(0, v); chk("R10 frozen low ch0", 32'(v), 32'h02);
    rd(0, v); chk("R10 frozen high ch0", 32'(v), 32'h01);
    rd(0, v); chk("R10 live after ch0", 32'(v), 32'hE0);
    rd(1, v); chk("R10 unselected ch1 live", 32'(v), 32'hC0);
    rd(2, v); chk("R11 status first ch2", 32'(v), 32'({1'b1, 1'b1, 2'b11, 3'd5, 1'b0}));
    rd(2, v); chk("R10 frozen low ch2", 32'(v), 32'h06);

    // R9 status latch ignored while unread
    wr(3, ctl(0, 2'b01, 3'd0, 1'b0));
    chOut = 3'b001;
    wr(3, 8'b1110_0010);
    chOut = 3'b000;
    wr(3, 8'b1110_0010);
    rd(0, v); chk("R9 first status kept", 32'(v), 32'({1'b1, 1'b1, 2'b01, 3'd0, 1'b0}));
    rd(0, v); chk("R11 status released", 32'(v), 32'(chLive[7:0]));

    // R12 null count
    chLoaded = 3'b001;
    @(negedge clk);
    chLoaded = 3'b000;
    readStatus(0, v); chk("R12 cleared by transfer", 32'(v[6]), 0);
    wr(0, 8'h40);
    readStatus(0, v); chk("R12 set by count write", 32'(v[6]), 1);
    chLoaded = 3'b001;
    @(negedge clk);
    wr(3, ctl(0, 2'b01, 3'd0, 1'b0));
    chLoaded = 3'b000;
    readStatus(0, v); chk("R12 set wins over transfer", 32'(v[6]), 1);

    // R13 control address reads
    wr(3, ctl(1, 2'b11, 3'd0, 1'b0));
    setLive(1, 16'h9A8B);
    rd(3, v); chk("R13 control read zero", 32'(v), 0);
    rd(1, v); chk("R13 no state change", 32'(v), 32'h8B);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule